// File: doc/BRIEF.md
# Match-Compare Interval Timer

This block is a software-programmed event timer. An up-counter advances by one on every tick of a small clock prescaler, and a match register holds the count at which the next event is due. When the counter steps onto the match value while the timer is running, the block gives a single-cycle interrupt pulse. Software can then either let the counter continue or have it fall back to zero automatically, which gives a periodic timer. The counter wraps around at its full width.

Software uses the block through a plain synchronous register port: a byte address, a write strobe, write data, and read data that is decoded combinationally from the address. The usual bring-up sequence is to stop the timer, zero the count, and park the match register at all-ones. To arm an event, software reads the count, adds a delay, and writes the sum to the match register. A delay of fewer than four ticks may be missed. A separate control word sets the prescaler to divide the system clock by one, two, three or four.

Top module: `match_timer`

## Requirements
- R1: After reset the match register reads 0xFFFFFFFF, and the count, the enable word and the divider code all read 0. The interrupt is low.
- R2: Register offsets, with word access only: 0x00 match (read/write, 32 bits), 0x04 count (read only), 0x08 enable (bit 0 run, bit 1 zero-on-match, upper bits read 0), 0x0C clear (write only, any data), 0x10 divider code (bits 1:0).
- R3: While run is 1, the count goes up by exactly one per prescaler tick. While run is 0, it holds its value.
- R4: With divider code c, the prescaler ticks once every c+1 system clocks, so any window of N*(c+1) clocks adds exactly N to a running count. A new code takes effect at the next tick boundary.
- R5: irq_o pulses high for one cycle when a running count becomes equal to the match value. It does not fire again while the count stays equal, whether the count is held by a slow prescaler or by the timer being stopped. It never fires while the timer is stopped.
- R6: With zero-on-match at 0, the counter keeps incrementing past the match value.
- R7: With zero-on-match at 1, the tick after the count reaches the match value loads zero instead of incrementing, so the count cycles through 0..match.
- R8: Any write to the clear offset makes the count 0 on the next cycle. A clear takes priority over a tick.
- R9: Reads of unmapped or misaligned addresses return 0. Writes to the count offset leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | One-cycle expiry pulse |

## Verification
The bench targets the points where a timer typically fails. It holds the count on the match value with a divide-by-4 prescaler; a level-detecting design would then raise the interrupt for four cycles instead of one. It re-enables a stopped timer whose count already equals the match value; a design without an edge condition would fire a stale event. It runs a zero-on-match loop for ten periods and checks the pulse count, the peak count and the final phase, which exposes an off-by-one reload (period match or match+2) and a counter that reloads on the wrong cycle. It also measures exact tick rates for every divider code, and checks that a clear wins against a tick that lands in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Word indices (byte offset >> 2) of the register map
  localparam int unsigned IDX_MATCH  = 0;
  localparam int unsigned IDX_COUNT  = 1;
  localparam int unsigned IDX_ENABLE = 2;
  localparam int unsigned IDX_CLEAR  = 3;
  localparam int unsigned IDX_DIVCTL = 4;

  // Enable-word bit positions
  localparam int unsigned EN_RUN_BIT  = 0;
  localparam int unsigned EN_WRAP_BIT = 1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [CODE_W-1:0] phase_q, phase_d;
  logic [CODE_W-1:0] lim_q, lim_d;

  always_comb begin
    tick_o  = (phase_q == lim_q);
    phase_d = tick_o ? '0 : phase_q + 1'b1;
    // new divider code latched only at a tick boundary
    lim_d   = tick_o ? code_i : lim_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      lim_q   <= '0;
    end else begin
      phase_q <= phase_d;
      lim_q   <= lim_d;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;
  logic             eq, eq_q;

  always_comb begin
    eq       = (count_q == match_i);
    count_en = clr_i | (tick_i & run_i);
    if (clr_i)
      count_d = '0;
    else if (wrap_i && eq)
      count_d = '0;
    else
      count_d = count_q + 1'b1;
    // fire only on the cycle equality appears
    irq_o   = run_i & eq & ~eq_q;
    count_o = count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      eq_q    <= 1'b0;
    end else begin
      if (count_en) count_q <= count_d;
      eq_q <= eq;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [CNT_W-1:0]  match_o,
  output logic              run_o,
  output logic              wrap_o,
  output logic [CODE_W-1:0] code_o,
  output logic              clr_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             wr_match, wr_enable, wr_div;
  logic [CNT_W-1:0] match_q;
  logic             run_q, wrap_q;
  logic [CODE_W-1:0] code_q;

  always_comb begin
    idx       = addr_i[ADDR_W-1:2];
    aligned   = (addr_i[1:0] == 2'b00);
    wr_match  = we_i & aligned & (idx == IDX_W'(IDX_MATCH));
    wr_enable = we_i & aligned & (idx == IDX_W'(IDX_ENABLE));
    wr_div    = we_i & aligned & (idx == IDX_W'(IDX_DIVCTL));
    clr_o     = we_i & aligned & (idx == IDX_W'(IDX_CLEAR));
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (idx)
        IDX_W'(IDX_MATCH):  rdata_o = match_q;
        IDX_W'(IDX_COUNT):  rdata_o = count_i;
        IDX_W'(IDX_ENABLE): begin
          rdata_o[EN_RUN_BIT]  = run_q;
          rdata_o[EN_WRAP_BIT] = wrap_q;
        end
        IDX_W'(IDX_DIVCTL): rdata_o[CODE_W-1:0] = code_q;
        default:            rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '1;
      run_q   <= 1'b0;
      wrap_q  <= 1'b0;
      code_q  <= '0;
    end else begin
      if (wr_match) match_q <= wdata_i;
      if (wr_enable) begin
        run_q  <= wdata_i[EN_RUN_BIT];
        wrap_q <= wdata_i[EN_WRAP_BIT];
      end
      if (wr_div) code_q <= wdata_i[CODE_W-1:0];
    end
  end

  always_comb begin
    match_o = match_q;
    run_o   = run_q;
    wrap_o  = wrap_q;
    code_o  = code_q;
  end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] match_val;
  logic             run, wrap_en, clr_req, tick;
  logic [DIV_W-1:0] div_code;

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CODE_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr_i(bus_addr), .we_i(bus_we), .wdata_i(bus_wdata),
    .count_i(count), .rdata_o(bus_rdata),
    .match_o(match_val), .run_o(run), .wrap_o(wrap_en),
    .code_o(div_code), .clr_o(clr_req)
  );

  tmr_prescaler #(.CODE_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .code_i(div_code), .tick_o(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run),
    .wrap_i(wrap_en), .clr_i(clr_req), .match_i(match_val),
    .count_o(count), .irq_o(irq_o)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             run,
  input logic             wrap,
  input logic             tick,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] match
);
  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> run);

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(count));

  assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && wrap && !clr && count == match) |=> (count == '0));

  assert_step_past_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !wrap && !clr) |=> (count == $past(count) + 1'b1));
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .run(run), .wrap(wrap_en),
  .tick(tick), .clr(clr_req), .count(count), .match(match_val)
);

// File: tb/sim_match_timer.sv
`timescale 1ns/1ps
module sim_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  match_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [4:0] A_MATCH = 5'h00, A_COUNT = 5'h04, A_EN = 5'h08,
                         A_CLR = 5'h0C, A_DIV = 5'h10;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = A_COUNT;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = A_COUNT;
  endtask

  task automatic quiesce();
    wr(A_EN, 32'h0);
    wr(A_DIV, 32'h0);
    wr(A_CLR, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_MATCH, v); check("R1", "match after reset", v, 32'hFFFF_FFFF);
    rd(A_COUNT, v); check("R1", "count after reset", v, 32'h0);
    rd(A_EN, v);    check("R1", "enable after reset", v, 32'h0);
    rd(A_DIV, v);   check("R1", "divider after reset", v, 32'h0);
    check("R1", "irq after reset", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_MATCH, 32'h1234_5678);
    rd(A_MATCH, v); check("R2", "match readback", v, 32'h1234_5678);
    wr(A_EN, 32'hFFFF_FFFE);
    rd(A_EN, v);    check("R2", "enable keeps bits 1:0 only", v, 32'h2);
    wr(A_EN, 32'h0);
    wr(A_DIV, 32'hFFFF_FFFE);
    rd(A_DIV, v);   check("R2", "divider code readback", v, 32'h2);
    wr(A_DIV, 32'h0);
  endtask

  task automatic t_run_stop();
    logic [31:0] v;
    quiesce();
    wr(A_EN, 32'h1);
    rd(A_COUNT, v); check("R3", "count at enable", v, 32'h0);
    repeat (10) @(negedge clk);
    rd(A_COUNT, v); check("R3", "count after 10 ticks", v, 32'd10);
    wr(A_EN, 32'h0);
    rd(A_COUNT, v);
    repeat (15) @(negedge clk);
    begin
      logic [31:0] v2;
      rd(A_COUNT, v2); check("R3", "count held while stopped", v2, v);
    end
  endtask

  task automatic t_divider();
    logic [31:0] a, b;
    for (int c = 0; c < 4; c++) begin
      quiesce();
      wr(A_DIV, 32'(c));
      wr(A_EN, 32'h1);
      repeat (9) @(negedge clk);
      rd(A_COUNT, a);
      repeat (10 * (c + 1)) @(negedge clk);
      rd(A_COUNT, b);
      check("R4", $sformatf("increments over 10 periods, code %0d", c), b - a, 32'd10);
    end
  endtask

  task automatic t_irq_once();
    int pulses = 0, wide = 0;
    logic prev = 1'b0;
    logic [31:0] at = '0, v;
    quiesce();
    wr(A_MATCH, 32'd20);
    wr(A_EN, 32'h1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      #1;
      if (irq_o) begin
        pulses++; at = bus_rdata;
        if (prev) wide++;
      end
      prev = irq_o;
    end
    check("R5", "pulse count, single match", 32'(pulses), 32'd1);
    check("R5", "count at pulse", at, 32'd20);
    check("R5", "pulse width over 1", 32'(wide), 32'd0);
    rd(A_COUNT, v);
    check("R6", "count runs past match", v, 32'd40);
  endtask

  task automatic t_irq_slow();
    int pulses = 0;
    logic [31:0] at = '0;
    quiesce();
    wr(A_DIV, 32'h3);
    wr(A_MATCH, 32'd5);
    wr(A_EN, 32'h1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      #1;
      if (irq_o) begin pulses++; at = bus_rdata; end
    end
    check("R5", "one pulse while count held 4 cycles", 32'(pulses), 32'd1);
    check("R5", "count at slow pulse", at, 32'd5);
  endtask

  task automatic t_stale();
    int pulses = 0;
    logic [31:0] v;
    quiesce();
    wr(A_MATCH, 32'd0);  // equal to the stopped count
    repeat (3) @(negedge clk);
    check("R5", "no irq while stopped and equal", {31'b0, irq_o}, 32'h0);
    wr(A_EN, 32'h1);
    #1 if (irq_o) pulses++;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      if (irq_o) pulses++;
    end
    check("R5", "no stale pulse on enable", 32'(pulses), 32'd0);
    rd(A_COUNT, v);
    check("R3", "count moved after enable", v, 32'd6);
  endtask

  task automatic t_wrap();
    int pulses = 0;
    logic [31:0] mx = '0, v;
    quiesce();
    wr(A_MATCH, 32'd5);
    wr(A_EN, 32'h3);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if (irq_o) pulses++;
      if (bus_rdata > mx) mx = bus_rdata;
    end
    check("R7", "pulses over 10 periods", 32'(pulses), 32'd10);
    check("R7", "peak count", mx, 32'd5);
    rd(A_COUNT, v);
    check("R7", "phase after 60 ticks", v, 32'd0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    quiesce();
    wr(A_EN, 32'h1);
    repeat (12) @(negedge clk);
    wr(A_CLR, 32'hA5A5_A5A5);
    rd(A_COUNT, v); check("R8", "count zero after clear while ticking", v, 32'h0);
    @(negedge clk);
    rd(A_COUNT, v); check("R8", "count resumes after clear", v, 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v, w;
    quiesce();
    wr(A_EN, 32'h1);
    repeat (7) @(negedge clk);
    wr(A_EN, 32'h0);
    rd(A_COUNT, v);
    wr(A_COUNT, 32'hDEAD_BEEF);
    rd(A_COUNT, w); check("R9", "write to count ignored", w, v);
    rd(5'h14, w);   check("R9", "unmapped 0x14 reads zero", w, 32'h0);
    rd(5'h1C, w);   check("R9", "unmapped 0x1C reads zero", w, 32'h0);
    wr(A_MATCH, 32'hFFFF_0000);
    rd(5'h01, w);   check("R9", "misaligned read zero", w, 32'h0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_addr = A_COUNT;
    t_reset();
    t_regmap();
    t_run_stop();
    t_divider();
    t_irq_once();
    t_irq_slow();
    t_stale();
    t_wrap();
    t_clear();
    t_unmapped();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule